// File: doc/BRIEF.md
# Staircase Step Value Estimator

This block sits between a 16-bit parallel ADC and the test logic of a closed-loop gyroscope demodulator bench. It watches the feedback staircase that the demodulator produces. That staircase is built by adding a step value on every sample, and it carries two other effects: a square-wave offset that flips polarity periodically, and high/low resets that fold the accumulator back across full scale. The block starts conversions on a fixed grid of clock cycles and captures each word when the converter reports it is done. From those samples it recovers the step value S, the sign of the step, and the half-period of the square-wave modulation.

Every new sample is compared with the one before it, and each difference is sorted into one of three kinds. A small difference is an ordinary step: it votes on the sign and enters the running sum. A difference larger than half of full scale is a reset fold: it is unwrapped by one full-scale span, enters the sum, and takes no part in the vote. A difference of medium size is a square-wave edge, and it only sets the period measurement. Once sixteen differences have been accepted, the sum divided by sixteen is published as S, together with the sign that the vote decided.

Top module: `stair_step_est`

## Requirements
- R1: `adc_cnvst` is a pulse one clock wide that occurs once every SAMPLE_DIV clock cycles (50 by default).
- R2: A data word is captured on the first rising clock edge at which `adc_busy` is seen low after being seen high on the previous edge. Data presented on any later cycle is not used.
- R3: When the magnitude of the adjacent difference (current minus previous sample, both unsigned) is less than or equal to `jump_thresh`, the difference counts as a step. A step enters the sum unchanged. It adds one to the sign vote if positive, subtracts one if negative, and leaves the vote alone if zero. Equality with the threshold still counts as a step.
- R4: When the difference magnitude exceeds `jump_thresh` and is at least 2^(DATA_W-1), the difference is a reset fold. It is unwrapped by adding 2^DATA_W when negative and subtracting 2^DATA_W when positive. The unwrapped value enters the sum, and the vote is not changed.
- R5: A difference whose magnitude exceeds `jump_thresh` but is below 2^(DATA_W-1) is a jump. It never enters the sum or the vote. A jump counts as a polarity edge when it is the first edge since reset, or when its direction is opposite to the previous edge. On an edge, `period_out` takes the number of samples captured since the previous edge, counting the edge sample. For the first edge, the count starts at the first sample after reset. A jump in the same direction as the previous edge is dropped entirely.
- R6: When the sixteenth difference has been accepted (steps plus folds), the next clock edge does four things. It sets `step_out` to the arithmetic right shift by 4 of the sum of those sixteen values. It sets `step_neg` to 1 if the final vote is negative and 0 if it is zero or positive. It raises `result_valid` for exactly one clock. It clears the sum and the vote.
- R7: While `rst_n` is low, `step_out`, `step_neg`, `period_out`, `result_valid` and `adc_cnvst` are all 0.
- R8: `step_out` and `step_neg` change only in a cycle where `result_valid` is high. `period_out` changes only in the clock after a sample capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jump_thresh | input | DATA_W | Largest difference magnitude still treated as a step |
| adc_busy | input | 1 | Converter busy flag |
| adc_data | input | DATA_W | Parallel conversion result |
| adc_cnvst | output | 1 | Conversion-start pulse |
| step_out | output | DATA_W+1 | Signed step estimate S |
| step_neg | output | 1 | Step sign decided by the vote, 1 = negative |
| period_out | output | PERIOD_W | Samples between square-wave polarity edges |
| result_valid | output | 1 | One-clock strobe when S updates |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 50-cycle sampling grid and a 16-sample window. With 16-bit words, a staircase that starts near either end of the range crosses full scale within a few dozen samples, so reset folds occur in both directions inside one averaging window. The 50-cycle grid leaves room for a converter model whose busy time is four cycles and which drives a poison value one cycle after busy falls. A capture taken one cycle late would therefore corrupt S. Square-wave half-periods of 5 and 8 samples give several polarity edges per window, and a ratchet pattern of repeated same-direction jumps shows that such jumps are dropped.

// File: rtl/stair_pkg.sv
package stair_pkg;

    // Classification of one adjacent-sample difference
    typedef enum logic [1:0] {
        K_STEP = 2'd0,   // within threshold: ordinary step
        K_WRAP = 2'd1,   // beyond half scale: accumulator reset fold
        K_JUMP = 2'd2    // medium jump: square-wave polarity candidate
    } diff_kind_e;

endpackage

// File: rtl/stair_adc_seq.sv
module stair_adc_seq #(
    parameter int DATA_W     = 16,
    parameter int SAMPLE_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_busy,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_cnvst,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_vld
);

    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              busy;
        logic              cnvst;
        logic              vld;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.cnvst = (seq_q.div == '0);
        seq_d.div   = (seq_q.div == DIV_LAST) ? '0 : seq_q.div + 1'b1;
        seq_d.busy  = adc_busy;
        seq_d.vld   = 1'b0;
        // first edge with busy low after an edge with busy high
        if (seq_q.busy && !adc_busy) begin
            seq_d.vld  = 1'b1;
            seq_d.data = adc_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign adc_cnvst = seq_q.cnvst;
    assign smp_data  = seq_q.data;
    assign smp_vld   = seq_q.vld;

    // R1
    cnvst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnvst |=> !adc_cnvst);

    // R2
    capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> ($past(adc_busy, 2) && !$past(adc_busy)));

endmodule

// File: rtl/stair_diff_cls.sv
module stair_diff_cls
    import stair_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]  cur,
    input  logic [DATA_W-1:0]  prev,
    input  logic [DATA_W-1:0]  thresh,
    output diff_kind_e         kind,
    output logic signed [DATA_W:0] comp,
    output logic               fall
);

    localparam logic [DATA_W:0]          HALF = {2'b01, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W+1:0] FULL = {2'b01, {DATA_W{1'b0}}};

    logic signed [DATA_W:0]   raw;
    logic [DATA_W:0]          mag;
    logic signed [DATA_W+1:0] ext;
    logic signed [DATA_W+1:0] wide;

    always_comb begin
        raw  = $signed({1'b0, cur}) - $signed({1'b0, prev});
        mag  = raw[DATA_W] ? (DATA_W+1)'(-raw) : raw;
        ext  = {raw[DATA_W], raw};
        fall = raw[DATA_W];
        kind = K_STEP;
        wide = ext;
        if (mag > {1'b0, thresh}) begin
            if (mag >= HALF) begin
                kind = K_WRAP;
                wide = fall ? ext + FULL : ext - FULL;
            end else begin
                kind = K_JUMP;
            end
        end
        comp = wide[DATA_W:0];
    end

endmodule

// File: rtl/stair_accum.sv
module stair_accum
    import stair_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int AVG_LOG2 = 4,
    parameter int PERIOD_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_vld,
    input  logic [DATA_W-1:0]      smp_data,
    input  logic [DATA_W-1:0]      thresh,
    output logic signed [DATA_W:0] step_out,
    output logic                   step_neg,
    output logic [PERIOD_W-1:0]    period_out,
    output logic                   result_valid
);

    localparam int SUM_W  = DATA_W + 1 + AVG_LOG2;
    localparam int VOTE_W = AVG_LOG2 + 2;

    typedef struct packed {
        logic [DATA_W-1:0]       prev;
        logic                    have_prev;
        logic signed [SUM_W-1:0] sum;
        logic [AVG_LOG2-1:0]     cnt;
        logic signed [VOTE_W-1:0] vote;
        logic signed [DATA_W:0]  step;
        logic                    neg;
        logic                    valid;
        logic [PERIOD_W-1:0]     per_cnt;
        logic [PERIOD_W-1:0]     period;
        logic                    edge_seen;
        logic                    edge_fall;
    } acc_t;

    acc_t acc_d, acc_q;

    diff_kind_e               kind;
    logic signed [DATA_W:0]   comp;
    logic                     fall;
    logic signed [VOTE_W-1:0] vote_nx;
    logic signed [SUM_W-1:0]  tot;
    logic signed [SUM_W-1:0]  avg;
    logic [PERIOD_W-1:0]      per_nx;
    logic                     accept;

    stair_diff_cls #(.DATA_W(DATA_W)) u_cls (
        .cur    (smp_data),
        .prev   (acc_q.prev),
        .thresh (thresh),
        .kind   (kind),
        .comp   (comp),
        .fall   (fall)
    );

    always_comb begin
        acc_d       = acc_q;
        acc_d.valid = 1'b0;
        accept      = 1'b0;
        vote_nx     = acc_q.vote;
        per_nx      = (&acc_q.per_cnt) ? acc_q.per_cnt : acc_q.per_cnt + 1'b1;
        tot         = acc_q.sum + $signed({{AVG_LOG2{comp[DATA_W]}}, comp});
        avg         = tot >>> AVG_LOG2;
        if (smp_vld) begin
            acc_d.prev      = smp_data;
            acc_d.have_prev = 1'b1;
            acc_d.per_cnt   = per_nx;
            if (acc_q.have_prev) begin
                case (kind)
                    K_STEP: begin
                        accept = 1'b1;
                        if (comp > 0)      vote_nx = acc_q.vote + VOTE_W'(1);
                        else if (comp < 0) vote_nx = acc_q.vote - VOTE_W'(1);
                    end
                    K_WRAP: accept = 1'b1;
                    K_JUMP: begin
                        if (!acc_q.edge_seen || (fall != acc_q.edge_fall)) begin
                            acc_d.period    = per_nx;
                            acc_d.per_cnt   = '0;
                            acc_d.edge_seen = 1'b1;
                            acc_d.edge_fall = fall;
                        end
                    end
                    default: ;
                endcase
                if (accept) begin
                    if (acc_q.cnt == '1) begin
                        acc_d.step  = avg[DATA_W:0];
                        acc_d.neg   = vote_nx[VOTE_W-1];
                        acc_d.valid = 1'b1;
                        acc_d.sum   = '0;
                        acc_d.cnt   = '0;
                        acc_d.vote  = '0;
                    end else begin
                        acc_d.sum  = tot;
                        acc_d.cnt  = acc_q.cnt + 1'b1;
                        acc_d.vote = vote_nx;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign step_out     = acc_q.step;
    assign step_neg     = acc_q.neg;
    assign period_out   = acc_q.period;
    assign result_valid = acc_q.valid;

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R8
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(step_out) && $stable(step_neg)));

    // R8
    period_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(period_out) |-> $past(smp_vld));

endmodule

// File: rtl/stair_step_est.sv
module stair_step_est #(
    parameter int DATA_W     = 16,
    parameter int SAMPLE_DIV = 50,
    parameter int AVG_LOG2   = 4,
    parameter int PERIOD_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DATA_W-1:0]      jump_thresh,
    input  logic                   adc_busy,
    input  logic [DATA_W-1:0]      adc_data,
    output logic                   adc_cnvst,
    output logic signed [DATA_W:0] step_out,
    output logic                   step_neg,
    output logic [PERIOD_W-1:0]    period_out,
    output logic                   result_valid
);

    logic [DATA_W-1:0] smp_data;
    logic              smp_vld;

    stair_adc_seq #(
        .DATA_W     (DATA_W),
        .SAMPLE_DIV (SAMPLE_DIV)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_busy  (adc_busy),
        .adc_data  (adc_data),
        .adc_cnvst (adc_cnvst),
        .smp_data  (smp_data),
        .smp_vld   (smp_vld)
    );

    stair_accum #(
        .DATA_W   (DATA_W),
        .AVG_LOG2 (AVG_LOG2),
        .PERIOD_W (PERIOD_W)
    ) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_vld      (smp_vld),
        .smp_data     (smp_data),
        .thresh       (jump_thresh),
        .step_out     (step_out),
        .step_neg     (step_neg),
        .period_out   (period_out),
        .result_valid (result_valid)
    );

endmodule

// File: tb/tb_stair_step_est.sv
module tb_stair_step_est;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [15:0]        jump_thresh;
    logic               adc_busy;
    logic [15:0]        adc_data;
    logic               adc_cnvst;
    logic signed [16:0] step_out;
    logic               step_neg;
    logic [15:0]        period_out;
    logic               result_valid;

    always #2.5 clk = ~clk;   // 200 MHz

    stair_step_est dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .jump_thresh  (jump_thresh),
        .adc_busy     (adc_busy),
        .adc_data     (adc_data),
        .adc_cnvst    (adc_cnvst),
        .step_out     (step_out),
        .step_neg     (step_neg),
        .period_out   (period_out),
        .result_valid (result_valid)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // staircase shape, set per vector
    int cur_step, cur_amp, cur_half, cur_mode, cur_base;

    // columns: step, amp, half, mode(0 square,1 ratchet), base, thresh, exp_s, exp_neg, exp_period
    localparam int NV = 8;
    localparam int TBL [NV][9] = '{
        '{  100,     0, 1000, 0,     0, 2000,  100, 0, 0},  // R2 plain rising
        '{  -37,     0, 1000, 0,  1000, 2000,  -37, 1, 0},  // R4 folds from below zero
        '{ 3000,     0, 1000, 0, 60000, 4000, 3000, 0, 0},  // R4 folds past full scale
        '{   50,  8000,    5, 0,   100, 2000,   50, 0, 5},  // R5 square wave
        '{    0,     0, 1000, 0, 30000, 2000,    0, 0, 0},  // R6 flat, tied vote
        '{ 2000,     0, 1000, 0,     0, 2000, 2000, 0, 0},  // R3 diff equal to threshold
        '{   -5, 10000,    8, 0, 30000, 2000,   -5, 1, 8},  // R5 square wave, falling
        '{   10,  3000,    6, 1,     0, 2000,   10, 0, 7}   // R5 same-direction jumps dropped
    };

    function automatic logic [15:0] gen(int k);
        int v;
        if (cur_mode == 0) v = cur_base + cur_step * k + ((((k / cur_half) % 2) == 1) ? cur_amp : 0);
        else               v = cur_base + cur_step * k + cur_amp * (k / cur_half);
        return v[15:0];
    endfunction

    function automatic string tag(int r);
        case (r)
            0:       return "R2";
            1, 2:    return "R4";
            5:       return "R3";
            3, 6, 7: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // converter model; data is poisoned one cycle after busy falls (R2)
    int k_idx;
    initial begin
        adc_busy = 1'b0;
        adc_data = 16'h0;
        k_idx    = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) k_idx = 0;
            else if (adc_cnvst) begin
                adc_busy = 1'b1;
                repeat (4) @(negedge clk);
                adc_busy = 1'b0;
                adc_data = gen(k_idx);
                k_idx++;
                @(negedge clk);
                adc_data = 16'hDEAD;
            end
        end
    end

    // output monitor
    int vcnt = 0;
    int last_s = 0;
    int last_neg = 0;
    int hold_err = 0;
    int width_err = 0;
    logic signed [16:0] prev_s = '0;
    logic prev_neg = 1'b0;
    logic prev_valid = 1'b0;
    logic prev_rst = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) vcnt = 0;
        else begin
            if (result_valid) begin
                vcnt++;
                last_s   = step_out;
                last_neg = step_neg;
                if (prev_valid) width_err++;
            end else if (prev_rst && (step_out !== prev_s || step_neg !== prev_neg)) begin
                hold_err++;
            end
        end
        prev_s     = step_out;
        prev_neg   = step_neg;
        prev_valid = result_valid;
        prev_rst   = rst_n;
    end

    task automatic do_reset();
        @(negedge clk);
        while (!adc_cnvst) @(negedge clk);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        rst_n       = 1'b0;
        jump_thresh = 16'd2000;
        cur_step = TBL[0][0]; cur_amp = TBL[0][1]; cur_half = TBL[0][2];
        cur_mode = TBL[0][3]; cur_base = TBL[0][4];
        repeat (5) @(negedge clk);
        // R7 reset state
        chk(step_out == 0,     "R7", "step_out in reset",     int'(step_out), 0);
        chk(step_neg == 1'b0,  "R7", "step_neg in reset",     int'(step_neg), 0);
        chk(period_out == 0,   "R7", "period_out in reset",   int'(period_out), 0);
        chk(!result_valid,     "R7", "result_valid in reset", int'(result_valid), 0);
        chk(!adc_cnvst,        "R7", "adc_cnvst in reset",    int'(adc_cnvst), 0);
        rst_n = 1'b1;

        // R1 pulse width and grid spacing
        begin
            int n;
            logic w;
            @(negedge clk);
            while (!adc_cnvst) @(negedge clk);
            @(negedge clk);
            w = adc_cnvst;
            n = 1;
            while (!adc_cnvst) begin @(negedge clk); n++; end
            chk(w == 1'b0, "R1", "cnvst width", int'(w), 0);
            chk(n == 50,   "R1", "cnvst spacing", n, 50);
        end

        // vector table
        for (int r = 0; r < NV; r++) begin
            int t;
            cur_step = TBL[r][0]; cur_amp = TBL[r][1]; cur_half = TBL[r][2];
            cur_mode = TBL[r][3]; cur_base = TBL[r][4];
            jump_thresh = 16'(TBL[r][5]);
            do_reset();
            t = 0;
            while (vcnt < 3 && t < 20000) begin @(negedge clk); t++; end
            chk(vcnt >= 3, "R6", $sformatf("row %0d result count", r), vcnt, 3);
            chk(last_s == TBL[r][6], tag(r), $sformatf("row %0d step_out (R6)", r), last_s, TBL[r][6]);
            chk(last_neg == TBL[r][7], "R6", $sformatf("row %0d step_neg", r), last_neg, TBL[r][7]);
            chk(int'(period_out) == TBL[r][8], "R5", $sformatf("row %0d period_out", r),
                int'(period_out), TBL[r][8]);
        end

        // R8 hold between strobes, R6 strobe width
        chk(hold_err == 0,  "R8", "changes without strobe", hold_err, 0);
        chk(width_err == 0, "R6", "strobe longer than one clock", width_err, 0);

        // R7 reset in mid-run clears results
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(step_out == 0,   "R7", "step_out after mid reset",   int'(step_out), 0);
        chk(period_out == 0, "R7", "period_out after mid reset", int'(period_out), 0);
        chk(!result_valid,   "R7", "result_valid after mid reset", int'(result_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule